// File: doc/BRIEF.md
# Phase-Error Lock Monitor

This block decides whether a digital PLL has settled onto its reference. Each cycle it may receive one signed two's-complement sample from the phase detector, which gives the offset between the incoming reference and the feedback clock. A one-cycle tick input marks the edges of fixed observation windows. In real use the tick is 4 ms apart; a test can use a much shorter window.

A window passes when no valid sample in it reaches the programmed threshold in absolute value. The lock flag is raised once a programmed number of passing windows have occurred in a row. A single failing window lowers the flag and restarts the run. A small register port lets software write the threshold and the required window count and read the lock flag. Any write to either setting restarts the run and clears the flag.

Top module: `plock_detect`

## Requirements
- R1: After reset the lock flag is 0, the threshold reads back as THR_RST (default 512) and the window count reads back as IVL_RST (default 4).
- R2: A valid sample fails its window when its absolute value, taken as a signed two's-complement number, is greater than or equal to the threshold. The most negative code counts as magnitude 2^(PHASE_W-1). A sample whose magnitude is exactly equal to the threshold fails.
- R3: A sample presented while phase_vld_i is 0 has no effect on the window result.
- R4: A window closes in the cycle tick_i is 1. A sample in that same cycle belongs to the window that is closing. The next window starts clean.
- R5: lock_o goes to 1 in the cycle after the tick that closes the N-th consecutive passing window, where N is the window-count setting.
- R6: A window-count setting of 0 behaves as 1.
- R7: In the cycle after a tick that closes a failing window, lock_o is 0 and the consecutive count restarts from zero.
- R8: While lock_o is 1, each further passing window keeps it at 1.
- R9: A write to the threshold (address 0) or the window count (address 1) clears lock_o on the next cycle, discards the current window's failure mark and restarts the count. A write wins over a tick in the same cycle.
- R10: The register map is as follows. Address 0 holds the threshold in bits [PHASE_W-1:0]. Address 1 holds the window count in bits [CNT_W-1:0]. Address 2 is read-only status, with bit 0 = lock and all other bits 0. Address 3 reads as 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse that closes the current window |
| phase_vld_i | input | 1 | phase_i carries a sample this cycle |
| phase_i | input | PHASE_W | Signed phase-error sample |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational from the address) |
| lock_o | output | 1 | Lock flag |

## Verification
The run first uses windows of samples that sit just inside and exactly on the threshold, of both signs. This separates a magnitude compare from a one-sided compare and from an off-by-one compare. It then uses large samples marked not valid, and an out-of-range sample placed exactly on the tick cycle. Together these show whether invalid samples are ignored and whether the boundary sample is charged to the closing window rather than to the next one. A window count of zero, the most negative code, and writes that collide with a tick probe the edge cases. A long seeded random mix of sample sizes, tick spacing and register writes is then compared cycle by cycle against a bench reference model.

// File: rtl/plock_pkg.sv
// Shared definitions for the phase-error lock monitor.
// Holds the register address map and the position of the lock bit in the
// status word. Assumes a 2-bit register address.
package plock_pkg;

    typedef enum logic [1:0] {
        ADDR_THR  = 2'd0,
        ADDR_IVL  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_RSVD = 2'd3
    } plock_addr_e;

    localparam int STAT_LOCK_BIT = 0;

endpackage

// File: rtl/plock_mag.sv
// Sample magnitude comparator.
// Takes the absolute value of a signed two's-complement phase sample and
// flags it when it reaches the threshold. The most negative code maps to
// 2^(PHASE_W-1), which still fits in PHASE_W unsigned bits.
// Assumes the threshold is unsigned and PHASE_W bits wide. Purely combinational.
module plock_mag #(
    parameter int PHASE_W = 16
) (
    input  logic               vld_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [PHASE_W-1:0] thr_i,
    output logic               exceed_o
);

    logic [PHASE_W-1:0] mag;

    // Absolute value: negate the code when the sign bit is set.
    always_comb begin
        if (phase_i[PHASE_W-1]) begin
            mag = PHASE_W'(~phase_i + 1'b1);
        end else begin
            mag = phase_i;
        end
    end

    // A sample counts only when it is valid.
    always_comb begin
        exceed_o = vld_i && (mag >= thr_i);
    end

endmodule

// File: rtl/plock_window.sv
// Window failure tracker.
// Holds a sticky mark that is set by any over-threshold sample inside the
// current window. The window result shown on the tick cycle also includes
// that cycle's own sample. The mark clears on a tick or on a restart.
// Assumes tick_i is a single-cycle pulse.
module plock_window (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic exceed_i,
    input  logic restart_i,
    output logic win_fail_o
);

    logic fail_q;

    // Sticky failure mark for the window in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (restart_i || tick_i) begin
            fail_q <= 1'b0;
        end else if (exceed_i) begin
            fail_q <= 1'b1;
        end
    end

    // Result of the closing window, including the sample in the tick cycle.
    always_comb begin
        win_fail_o = fail_q || exceed_i;
    end

    // R4: a tick or a restart leaves the next window clean.
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i || restart_i) |=> !fail_q);

    // R2: once failed, a window stays failed until it closes.
    p_fail_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_q && !tick_i && !restart_i) |=> fail_q);

endmodule

// File: rtl/plock_count.sv
// Consecutive passing-window counter and lock flag.
// On each tick it either clears the run (failing window) or advances it
// (passing window). The flag is set when the run reaches the effective
// window count, which is the setting with 0 treated as 1. The run saturates
// at that count. A restart clears everything and takes priority over a tick.
module plock_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             win_fail_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] ivl_i,
    output logic             lock_o
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             lock_q;
    logic [CNT_W-1:0] ivl_eff;
    logic [EXT_W-1:0] cnt_next;

    // Effective window count: a setting of zero means one window.
    always_comb begin
        ivl_eff  = (ivl_i == '0) ? CNT_W'(1) : ivl_i;
        cnt_next = EXT_W'(cnt_q) + EXT_W'(1);
    end

    // Run length and lock flag, updated on window boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (tick_i) begin
            if (win_fail_i) begin
                cnt_q  <= '0;
                lock_q <= 1'b0;
            end else if (cnt_next >= EXT_W'(ivl_eff)) begin
                cnt_q  <= ivl_eff;
                lock_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_next[CNT_W-1:0];
            end
        end
    end

    assign lock_o = lock_q;

    // R7: a failing window drops the lock and clears the run.
    p_fail_drops_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && win_fail_i) |=> (!lock_q && cnt_q == '0));

    // R9: a setting write clears the lock and the run.
    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!lock_q && cnt_q == '0));

    // R5: lock can only rise right after a window boundary.
    p_lock_rise_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> ($past(tick_i) && !$past(restart_i)));

    // R8: lock holds unless a failing window or a restart occurs.
    p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !(tick_i && win_fail_i) && !restart_i) |=> lock_q);

    // R6: the run never exceeds the effective window count.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ivl_eff);

endmodule

// File: rtl/plock_regs.sv
// Settings registers and read mux.
// Holds the threshold and the window-count setting. Raises restart_o for a
// write to either one, and returns read data combinationally from the
// address. Writes to the status and reserved addresses are dropped.
// Assumes DATA_W >= PHASE_W and DATA_W >= CNT_W.
module plock_regs
    import plock_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 16,
    parameter int THR_RST = 512,
    parameter int IVL_RST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [1:0]         addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               lock_i,
    output logic [PHASE_W-1:0] thr_o,
    output logic [CNT_W-1:0]   ivl_o,
    output logic               restart_o,
    output logic [DATA_W-1:0]  rdata_o
);

    plock_addr_e addr;

    assign addr = plock_addr_e'(addr_i);

    // Threshold and window-count storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_o <= PHASE_W'(THR_RST);
            ivl_o <= CNT_W'(IVL_RST);
        end else if (wr_i) begin
            if (addr == ADDR_THR) begin
                thr_o <= wdata_i[PHASE_W-1:0];
            end
            if (addr == ADDR_IVL) begin
                ivl_o <= wdata_i[CNT_W-1:0];
            end
        end
    end

    // A write to either setting restarts the lock search.
    always_comb begin
        restart_o = wr_i && (addr == ADDR_THR || addr == ADDR_IVL);
    end

    // Read mux; unused bits read as zero.
    always_comb begin
        rdata_o = '0;
        case (addr)
            ADDR_THR:  rdata_o[PHASE_W-1:0] = thr_o;
            ADDR_IVL:  rdata_o[CNT_W-1:0]   = ivl_o;
            ADDR_STAT: rdata_o[STAT_LOCK_BIT] = lock_i;
            default:   rdata_o = '0;
        endcase
    end

    // Upper write-data bits that the window-count field does not use.
    generate
        if (DATA_W > CNT_W) begin : g_unused_hi
            logic unused_hi;
            assign unused_hi = ^wdata_i[DATA_W-1:CNT_W];
        end
    endgenerate

    // R10: the settings change only on a write to their own address.
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (addr == ADDR_THR || addr == ADDR_IVL))
            |=> ($stable(thr_o) && $stable(ivl_o)));

endmodule

// File: rtl/plock_detect.sv
// Phase-error lock monitor, top level.
// Connects the magnitude compare, the window failure tracker, the
// consecutive-window counter and the settings registers. Window edges come
// from tick_i, which in the field is 4 ms apart.
// Assumes tick_i and the register strobe are synchronous to clk.
module plock_detect #(
    parameter int PHASE_W = 16,
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 16,
    parameter int THR_RST = 512,
    parameter int IVL_RST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               phase_vld_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               lock_o
);

    logic [PHASE_W-1:0] thr;
    logic [CNT_W-1:0]   ivl;
    logic               restart;
    logic               exceed;
    logic               win_fail;
    logic               lock;

    plock_regs #(
        .PHASE_W (PHASE_W),
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W),
        .THR_RST (THR_RST),
        .IVL_RST (IVL_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .lock_i    (lock),
        .thr_o     (thr),
        .ivl_o     (ivl),
        .restart_o (restart),
        .rdata_o   (reg_rdata_o)
    );

    plock_mag #(
        .PHASE_W (PHASE_W)
    ) u_mag (
        .vld_i    (phase_vld_i),
        .phase_i  (phase_i),
        .thr_i    (thr),
        .exceed_o (exceed)
    );

    plock_window u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .exceed_i   (exceed),
        .restart_i  (restart),
        .win_fail_o (win_fail)
    );

    plock_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .win_fail_i (win_fail),
        .restart_i  (restart),
        .ivl_i      (ivl),
        .lock_o     (lock)
    );

    assign lock_o = lock;

    // R1: lock is low in the first cycle after reset.
    p_reset_unlocked_r1: assert property (@(posedge clk)
        !rst_n |=> !lock_o);

endmodule

// File: tb/sim_plock_detect.sv
`timescale 1ns/1ps
module sim_plock_detect;

    localparam int PW = 16;
    localparam int CW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          pv = 1'b0;
    logic [PW-1:0] ph = '0;
    logic          wr = 1'b0;
    logic [1:0]    ad = '0;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] rd;
    logic          lock;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model state
    int thr_m = 512;
    int ivl_m = 4;
    int cnt_m = 0;
    bit bad_m = 1'b0;
    bit lock_m = 1'b0;

    always #2.5 clk = ~clk;

    plock_detect #(.PHASE_W(PW), .CNT_W(CW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .phase_vld_i(pv),
        .phase_i(ph), .reg_wr_i(wr), .reg_addr_i(ad), .reg_wdata_i(wd),
        .reg_rdata_o(rd), .lock_o(lock)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus with a model update and a lock compare.
    task automatic cyc(input string tag, input bit v, input int p, input bit tk,
                       input bit w = 1'b0, input int a = 0, input int d = 0);
        int m;
        bit ex;
        int e;
        pv = v; ph = p[PW-1:0]; tick = tk; wr = w; ad = a[1:0]; wd = d[DW-1:0];
        m = int'($signed(ph));
        if (m < 0) m = -m;
        ex = v && (m >= thr_m);
        if (w && a < 2) begin
            if (a == 0) thr_m = d & 32'hFFFF;
            else        ivl_m = d & 32'hFF;
            cnt_m = 0; bad_m = 1'b0; lock_m = 1'b0;
        end else if (tk) begin
            if (bad_m || ex) begin
                cnt_m = 0; lock_m = 1'b0;
            end else begin
                e = (ivl_m == 0) ? 1 : ivl_m;
                if (cnt_m + 1 >= e) begin cnt_m = e; lock_m = 1'b1; end
                else cnt_m = cnt_m + 1;
            end
            bad_m = 1'b0;
        end else if (ex) begin
            bad_m = 1'b1;
        end
        @(posedge clk);
        #1;
        chk(tag, 32'(lock), 32'(lock_m));
        pv = 1'b0; tick = 1'b0; wr = 1'b0;
    endtask

    // Four-sample window, tick on the last sample.
    task automatic win(input string tag, input int s0, input int s1, input int s2, input int s3);
        cyc(tag, 1'b1, s0, 1'b0);
        cyc(tag, 1'b1, s1, 1'b0);
        cyc(tag, 1'b1, s2, 1'b0);
        cyc(tag, 1'b1, s3, 1'b1);
    endtask

    task automatic rdchk(input string tag, input int a, input int exp);
        @(negedge clk);
        ad = a[1:0];
        #1;
        chk(tag, 32'(rd), exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 lock", 32'(lock), 0);
        rdchk("R1 thr", 0, 512);
        rdchk("R1 ivl", 1, 4);
        rdchk("R1 stat", 2, 0);

        // Threshold 100, three windows needed
        cyc("R9", 1'b0, 0, 1'b0, 1'b1, 0, 100);
        cyc("R9", 1'b0, 0, 1'b0, 1'b1, 1, 3);
        rdchk("R10 thr", 0, 100);
        rdchk("R10 ivl", 1, 3);
        win("R2", 99, -99, 50, 0);
        win("R2", -99, 99, 0, 3);
        chk("R5 not yet", 32'(lock), 0);
        win("R5", 1, -1, 98, -98);
        chk("R5 locked", 32'(lock), 1);
        win("R8", 0, 0, 0, 0);
        chk("R8 hold", 32'(lock), 1);
        // magnitude equal to threshold, negative side
        win("R7", 10, -100, 0, 0);
        chk("R7 drop", 32'(lock), 0);

        // Invalid large samples are ignored
        for (int k = 0; k < 3; k++) begin
            cyc("R3", 1'b0, 30000, 1'b0);
            cyc("R3", 1'b0, -30000, 1'b1);
        end
        chk("R3 lock", 32'(lock), 1);

        // Out-of-range sample on the tick cycle fails the closing window
        win("R4", 0, 0, 0, 200);
        chk("R4 tick sample", 32'(lock), 0);
        win("R4", 0, 0, 0, 0);
        chk("R4 next clean", 32'(lock), 0);

        // Window count zero acts as one
        cyc("R6", 1'b0, 0, 1'b0, 1'b1, 1, 0);
        win("R6", 5, 5, 5, 5);
        chk("R6 lock", 32'(lock), 1);

        // Most negative code against a full-scale threshold
        cyc("R2", 1'b0, 0, 1'b0, 1'b1, 0, 32'h7FFF);
        win("R2", -32768, 0, 0, 0);
        chk("R2 most negative", 32'(lock), 0);
        win("R2", 32767, 0, 0, 0);
        chk("R2 equal", 32'(lock), 0);
        win("R2", 32766, -32767 + 1, 0, 0);
        chk("R2 below", 32'(lock), 1);

        // Writes to status and reserved addresses are dropped
        cyc("R10", 1'b0, 0, 1'b0, 1'b1, 2, 0);
        cyc("R10", 1'b0, 0, 1'b0, 1'b1, 3, 16'hFFFF);
        chk("R10 lock kept", 32'(lock), 1);
        rdchk("R10 stat", 2, 1);
        rdchk("R10 rsvd", 3, 0);
        rdchk("R10 thr kept", 0, 32'h7FFF);

        // Write colliding with a tick wins
        cyc("R9", 1'b1, 0, 1'b1, 1'b1, 1, 2);
        chk("R9 collide", 32'(lock), 0);
        rdchk("R9 ivl", 1, 2);

        // Seeded random mix
        for (int k = 0; k < 4000; k++) begin
            int r;
            int amp;
            bit w;
            int a;
            int d;
            r = int'($urandom_range(0, 99));
            amp = (r < 85) ? int'($urandom_range(0, 120)) : int'($urandom_range(0, 32767));
            if ($urandom_range(0, 1) == 1) amp = -amp;
            if (r == 7) amp = -32768;
            w = ($urandom_range(0, 199) == 0);
            a = int'($urandom_range(0, 3));
            d = (a == 1) ? int'($urandom_range(0, 3)) : int'($urandom_range(60, 300));
            cyc("R5 random", ($urandom_range(0, 3) != 0), amp,
                ($urandom_range(0, 5) == 0), w, a, d);
        end
        rdchk("R10 final stat", 2, 32'(lock_m));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule